// File: doc/BRIEF.md
# Microsequenced ADD Datapath

This block is a small multi-cycle processor core that executes one instruction at a time as a fixed series of register-transfer steps. A sequencer walks through seven steps per instruction. It moves the instruction pointer into an address register, waits one cycle for a synchronous instruction memory and captures the returned word in a data register. It copies that word into the instruction register and decodes it. It then adds two general-purpose registers into a holding register and writes the result back. Each step drives exactly one group of register loads.

Only register-to-register addition does any work. Every other opcode passes through the same seven steps without touching the register file or the sum register, and the instruction pointer still advances by four. The instruction memory is outside the block and sits on a plain read port. Debug outputs make the internal registers visible, and a registered debug read port gives access to the register file. The general-purpose registers are not cleared by reset. At configuration each register holds its own index value.

Top module: `mseq_add_core`

## Requirements
- R1: While reset is high and at the first sample after it falls, the step is 0, the instruction pointer, memory address, memory data, instruction and sum registers are 0, and `instr_done` and `imem_rd` are low. General-purpose register i initially holds the value i.
- R2: The step counter (`dbg_step`) runs through the encodings 0 (address), 1 (wait), 2 (data), 3 (instruction), 4 (decode), 5 (execute) and 6 (writeback), one clock each, and returns to 0 after 6. The value 7 never appears.
- R3: At the end of step 0 the memory address register loads the instruction pointer. `imem_addr` always shows the memory address register.
- R4: `imem_rd` is high exactly during step 1. The memory answers one cycle after the read. The memory data register captures that word at the end of step 2. The instruction register loads the memory data register at the end of step 3 and holds at all other times.
- R5: Instruction word layout: opcode in bits 31:26, addition opcode 6'h01, destination index in bits 25:21, first source in bits 20:16, second source in bits 15:11. Decode uses only the instruction register.
- R6: For an addition, the sum register takes the first source plus the second source, modulo 2^32, at the end of step 5. The destination register is still unchanged during step 6.
- R7: For an addition, the destination register takes the sum register's value at the end of step 6. All 32 registers are writable, index 0 included, and source and destination may coincide.
- R8: Any opcode other than addition leaves every general-purpose register and the sum register unchanged.
- R9: The instruction pointer increases by 4 at the end of step 6, for every opcode, and at no other time.
- R10: `instr_done` is high exactly during step 6, for one cycle per instruction.
- R11: `dbg_rdata` shows the register selected by `dbg_rsel` as it stood before the previous clock edge. A write on that same edge is not yet visible.
- R12: Reset asserted in the middle of an instruction returns the core to step 0 with the instruction pointer at 0 and leaves the general-purpose registers as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Instruction memory byte address (memory address register) |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the read strobe |
| instr_done | output | 1 | High during the writeback step |
| dbg_step | output | 3 | Current micro-step encoding |
| dbg_ip | output | AW | Instruction pointer |
| dbg_mar | output | AW | Memory address register |
| dbg_mdr | output | 32 | Memory data register |
| dbg_ir | output | 32 | Instruction register |
| dbg_temp | output | XLEN | Sum register |
| dbg_rsel | input | 5 | Register file debug read index |
| dbg_rdata | output | XLEN | Register file debug read data, one cycle latency |

## Verification
A sequencer that skips or repeats a step shows up on `dbg_step` and on the timing of `instr_done` and `imem_rd` in the same cycle. A wrong fetch path shows up within one to two cycles on `dbg_mdr` and `dbg_ir`, compared against the word the bench placed at the expected address. A wrong sum or wrong register index stays inside until writeback, then appears on `dbg_temp` and, one cycle after the write, on `dbg_rdata`. For that reason the bench compares every register against a bench-side model after each instruction. A write made one step early is caught by reading the destination register during the writeback step itself.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  // Instruction word layout
  localparam int IW      = 32;
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = 26;
  localparam int RIDX_W  = 5;
  localparam int DST_LSB = 21;
  localparam int SA_LSB  = 16;
  localparam int SB_LSB  = 11;
  localparam int NREGS   = 1 << RIDX_W;

  // Micro-step encoding; the order is the execution order
  typedef enum logic [2:0] {
    ST_ADDR = 3'd0,
    ST_WAIT = 3'd1,
    ST_MDR  = 3'd2,
    ST_IR   = 3'd3,
    ST_DEC  = 3'd4,
    ST_EXE  = 3'd5,
    ST_WB   = 3'd6
  } step_e;

  // Register-transfer enables for the current step
  typedef struct packed {
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic rf_rd;
    logic ld_temp;
    logic rf_we;
    logic ip_inc;
  } uctl_t;

endpackage

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter logic [OPC_W-1:0] ADD_OPC = 6'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] ir_opc,
  output step_e            step,
  output uctl_t            ctl,
  output logic             rd_q,
  output logic             done_q
);

  step_e step_q;
  step_e step_n;
  logic  add_q;

  always_comb begin
    if (step_q == ST_WB) step_n = ST_ADDR;
    else                 step_n = step_e'(step_q + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_ADDR;
      add_q  <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_n;
      rd_q   <= (step_n == ST_WAIT);
      done_q <= (step_n == ST_WB);
      if (step_q == ST_DEC) add_q <= (ir_opc == ADD_OPC);
    end
  end

  // Later steps see only the latched decode result
  always_comb begin
    ctl = '0;
    unique case (step_q)
      ST_ADDR: ctl.ld_mar  = 1'b1;
      ST_MDR:  ctl.ld_mdr  = 1'b1;
      ST_IR:   ctl.ld_ir   = 1'b1;
      ST_DEC:  ctl.rf_rd   = 1'b1;
      ST_EXE:  ctl.ld_temp = add_q;
      ST_WB: begin
        ctl.rf_we  = add_q;
        ctl.ip_inc = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  assign step = step_q;

endmodule

// File: rtl/mseq_regfile.sv
module mseq_regfile #(
  parameter int XLEN   = 32,
  parameter int IDXW   = 5,
  parameter int DEPTH  = 1 << IDXW
) (
  input  logic            clk,
  input  logic            rd_en,
  input  logic [IDXW-1:0] ra_a,
  input  logic [IDXW-1:0] ra_b,
  output logic [XLEN-1:0] qa,
  output logic [XLEN-1:0] qb,
  input  logic [IDXW-1:0] ra_dbg,
  output logic [XLEN-1:0] q_dbg,
  input  logic            we,
  input  logic [IDXW-1:0] wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs [DEPTH];

  // Configuration-time contents: each entry holds its own index
  initial begin
    for (int i = 0; i < DEPTH; i++) regs[i] = XLEN'(i);
  end

  always_ff @(posedge clk) begin
    if (we) regs[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      qa <= regs[ra_a];
      qb <= regs[ra_b];
    end
  end

  always_ff @(posedge clk) begin
    q_dbg <= regs[ra_dbg];
  end

endmodule

// File: rtl/mseq_add_core.sv
module mseq_add_core
  import mseq_pkg::*;
#(
  parameter int               XLEN    = 32,
  parameter int               AW      = 16,
  parameter logic [OPC_W-1:0] ADD_OPC = 6'h01
) (
  input  logic              clk,
  input  logic              rst,
  output logic [AW-1:0]     imem_addr,
  output logic              imem_rd,
  input  logic [IW-1:0]     imem_rdata,
  output logic              instr_done,
  output logic [2:0]        dbg_step,
  output logic [AW-1:0]     dbg_ip,
  output logic [AW-1:0]     dbg_mar,
  output logic [IW-1:0]     dbg_mdr,
  output logic [IW-1:0]     dbg_ir,
  output logic [XLEN-1:0]   dbg_temp,
  input  logic [RIDX_W-1:0] dbg_rsel,
  output logic [XLEN-1:0]   dbg_rdata
);

  localparam logic [AW-1:0] IP_STEP = AW'(4);

  step_e     step;
  uctl_t     ctl;
  logic [AW-1:0]   ip_q, mar_q;
  logic [IW-1:0]   mdr_q, ir_q;
  logic [XLEN-1:0] temp_q, src_a, src_b;

  wire [OPC_W-1:0]  f_opc = ir_q[OPC_LSB +: OPC_W];
  wire [RIDX_W-1:0] f_dst = ir_q[DST_LSB +: RIDX_W];
  wire [RIDX_W-1:0] f_sa  = ir_q[SA_LSB  +: RIDX_W];
  wire [RIDX_W-1:0] f_sb  = ir_q[SB_LSB  +: RIDX_W];

  mseq_ctrl #(.ADD_OPC(ADD_OPC)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ir_opc (f_opc),
    .step   (step),
    .ctl    (ctl),
    .rd_q   (imem_rd),
    .done_q (instr_done)
  );

  mseq_regfile #(.XLEN(XLEN), .IDXW(RIDX_W), .DEPTH(NREGS)) u_rf (
    .clk    (clk),
    .rd_en  (ctl.rf_rd),
    .ra_a   (f_sa),
    .ra_b   (f_sb),
    .qa     (src_a),
    .qb     (src_b),
    .ra_dbg (dbg_rsel),
    .q_dbg  (dbg_rdata),
    .we     (ctl.rf_we),
    .wa     (f_dst),
    .wd     (temp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      temp_q <= '0;
    end else begin
      if (ctl.ld_mar)  mar_q  <= ip_q;
      if (ctl.ld_mdr)  mdr_q  <= imem_rdata;
      if (ctl.ld_ir)   ir_q   <= mdr_q;
      if (ctl.ld_temp) temp_q <= src_a + src_b;
      if (ctl.ip_inc)  ip_q   <= ip_q + IP_STEP;
    end
  end

  assign imem_addr = mar_q;
  assign dbg_step  = step;
  assign dbg_ip    = ip_q;
  assign dbg_mar   = mar_q;
  assign dbg_mdr   = mdr_q;
  assign dbg_ir    = ir_q;
  assign dbg_temp  = temp_q;

endmodule

// File: rtl/mseq_add_core_chk.sv
module mseq_add_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    step,
  input logic [AW-1:0] ip,
  input logic [AW-1:0] mar,
  input logic [31:0]   mdr,
  input logic [31:0]   ir,
  input logic          done,
  input logic          rd
);

  AST_STEP_NO_SEVEN: assert property (@(posedge clk) disable iff (rst) step != 3'd7); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst) (step < 3'd6) |=> step == $past(step) + 3'd1); // R2
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst) (step == 3'd6) |=> step == 3'd0); // R2
  AST_MAR_FROM_IP: assert property (@(posedge clk) disable iff (rst) (step == 3'd0) |=> mar == $past(ip)); // R3
  AST_RD_IN_WAIT: assert property (@(posedge clk) disable iff (rst) rd == (step == 3'd1)); // R4
  AST_IR_FROM_MDR: assert property (@(posedge clk) disable iff (rst) (step == 3'd3) |=> ir == $past(mdr)); // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) (step != 3'd3) |=> $stable(ir)); // R4
  AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst) (step != 3'd6) |=> $stable(ip)); // R9
  AST_IP_ADVANCE: assert property (@(posedge clk) disable iff (rst) (step == 3'd6) |=> ip == $past(ip) + AW'(4)); // R9
  AST_DONE_IN_WB: assert property (@(posedge clk) disable iff (rst) done == (step == 3'd6)); // R10

endmodule

bind mseq_add_core mseq_add_core_chk #(.AW(AW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .step (dbg_step),
  .ip   (dbg_ip),
  .mar  (dbg_mar),
  .mdr  (dbg_mdr),
  .ir   (dbg_ir),
  .done (instr_done),
  .rd   (imem_rd)
);

// File: tb/mseq_add_core_test.sv
module mseq_add_core_test;

  localparam int XLEN = 32;
  localparam int AW   = 16;
  localparam int NPROG = 34;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic [AW-1:0]   imem_addr;
  logic            imem_rd;
  logic [31:0]     imem_rdata;
  logic            instr_done;
  logic [2:0]      dbg_step;
  logic [AW-1:0]   dbg_ip, dbg_mar;
  logic [31:0]     dbg_mdr, dbg_ir;
  logic [XLEN-1:0] dbg_temp, dbg_rdata;
  logic [4:0]      dbg_rsel;

  mseq_add_core #(.XLEN(XLEN), .AW(AW)) uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
    .imem_rdata(imem_rdata), .instr_done(instr_done), .dbg_step(dbg_step),
    .dbg_ip(dbg_ip), .dbg_mar(dbg_mar), .dbg_mdr(dbg_mdr), .dbg_ir(dbg_ir),
    .dbg_temp(dbg_temp), .dbg_rsel(dbg_rsel), .dbg_rdata(dbg_rdata)
  );

  // Synchronous instruction memory, one-cycle latency
  logic [31:0] mem [64];
  always_ff @(posedge clk) begin
    if (imem_rd) imem_rdata <= mem[imem_addr[7:2]];
  end

  // Bench-side model
  logic [XLEN-1:0] mrf [32];
  logic [AW-1:0]   mip;
  logic [XLEN-1:0] mtemp;
  logic [4:0]      prev_dr;
  bit              have_prev, prev_add;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    return {opc, d, a, b, 11'd0};
  endfunction

  // One instruction, sampled at each negedge of its seven steps
  task automatic run_instr();
    logic [31:0] w;
    logic        is_add;
    logic [4:0]  d, a, b;
    logic [XLEN-1:0] sum;
    w      = mem[mip[7:2]];
    is_add = (w[31:26] == 6'h01);
    d = w[25:21]; a = w[20:16]; b = w[15:11];
    sum = mrf[a] + mrf[b];
    for (int k = 0; k < 7; k++) begin
      chk("R2", "step", 64'(dbg_step), 64'(k));
      chk("R10", "done", 64'(instr_done), 64'(k == 6));
      chk("R4", "read strobe", 64'(imem_rd), 64'(k == 1));
      if (k == 0) chk("R9", "ip", 64'(dbg_ip), 64'(mip));
      if (k == 1) begin
        chk("R3", "mar", 64'(dbg_mar), 64'(mip));
        chk("R3", "imem_addr", 64'(imem_addr), 64'(mip));
        if (have_prev) chk(prev_add ? "R7" : "R8", "register after writeback", 64'(dbg_rdata), 64'(mrf[prev_dr]));
      end
      if (k == 3) chk("R4", "mdr", 64'(dbg_mdr), 64'(w));
      if (k == 4) chk("R4", "ir", 64'(dbg_ir), 64'(w));
      if (k == 5) dbg_rsel = d;
      if (k == 6) begin
        chk(is_add ? "R5,R6" : "R8", "temp", 64'(dbg_temp), 64'(is_add ? sum : mtemp));
        chk("R6", "destination before writeback", 64'(dbg_rdata), 64'(mrf[d]));
      end
      @(negedge clk);
    end
    if (is_add) begin
      mrf[d] = sum;
      mtemp  = sum;
    end
    mip      = mip + AW'(4);
    prev_dr  = d;
    prev_add = is_add;
    have_prev = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    dbg_rsel = 5'd5;
    repeat (3) @(negedge clk);
    chk("R1", "gpr init r5", 64'(dbg_rdata), 64'd5);
    chk("R1", "step in reset", 64'(dbg_step), 64'd0);
    rst = 1'b0;
    chk("R1", "step", 64'(dbg_step), 64'd0);
    chk("R1", "ip", 64'(dbg_ip), 64'd0);
    chk("R1", "mar", 64'(dbg_mar), 64'd0);
    chk("R1", "mdr", 64'(dbg_mdr), 64'd0);
    chk("R1", "ir", 64'(dbg_ir), 64'd0);
    chk("R1", "temp", 64'(dbg_temp), 64'd0);
    chk("R1", "done", 64'(instr_done), 64'd0);
    chk("R1", "read strobe", 64'(imem_rd), 64'd0);
    mip = '0; mtemp = '0; have_prev = 1'b0;
  endtask

  task automatic t_program(input int n);
    for (int i = 0; i < n; i++) run_instr();
    chk("R7", "r31 after doublings", 64'(mrf[31]), 64'h0000_0000_C000_0000);
  endtask

  // R11: debug read port latency, using the words following the program (no-ops)
  task automatic t_debug_read();
    logic [4:0] sel_prev;
    sel_prev = 5'd3;
    dbg_rsel = sel_prev;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      logic [4:0] s;
      s = 5'(i * 9 + 1);
      dbg_rsel = s;
      chk("R11", "debug read", 64'(dbg_rdata), 64'(mrf[sel_prev]));
      @(negedge clk);
      chk("R11", "debug read next", 64'(dbg_rdata), 64'(mrf[s]));
      sel_prev = s;
    end
  endtask

  task automatic t_midrun_reset();
    while (dbg_step != 3'd3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R12", "step after reset", 64'(dbg_step), 64'd0);
    chk("R12", "ip after reset", 64'(dbg_ip), 64'd0);
    mip = '0; mtemp = '0; have_prev = 1'b0;
    for (int i = 0; i < 4; i++) run_instr();
    chk("R12", "r7 kept and doubled again", 64'(mrf[7]), 64'd28);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) mrf[i] = XLEN'(i);
    mem[0] = enc(6'h01, 5'd3, 5'd1, 5'd2);   // r3 = r1 + r2
    mem[1] = enc(6'h3F, 5'd1, 5'd2, 5'd3);   // not an addition
    mem[2] = enc(6'h01, 5'd7, 5'd7, 5'd7);   // r7 = r7 + r7
    mem[3] = enc(6'h01, 5'd0, 5'd4, 5'd5);   // r0 = r4 + r5
    for (int i = 4; i < NPROG; i++) mem[i] = enc(6'h01, 5'd31, 5'd31, 5'd31);
    rst = 1'b1;
    dbg_rsel = '0;
    @(negedge clk);
    t_reset();
    t_program(NPROG);
    t_debug_read();
    t_midrun_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule